// File: doc/BRIEF.md
# Dual-Loop Bias Code Calibration Controller

This controller picks a bias setting for a read-assist current source by running two counter searches against two worst-case detector inputs. The lower-bound loop starts at the top code and counts down, one code per step, until its detector reports a settled read of zero. The upper-bound loop starts at code zero and counts up until its detector reports a settled read of one. Each loop freezes its code as soon as it trips.

When both loops are frozen, the controller publishes the rounded-down midpoint of the two codes as the bias code and raises a done flag. A crossed pair of bounds, where the lower bound sits above the upper bound, is flagged, and the lower bound is published instead. A loop that reaches the far end of its range without a trip raises its own fail flag and stops there.

A recalibration pulse restarts both searches from their start codes, for example after a supply or temperature change. The published bias code keeps its last value until a new calibration completes. The detectors are external and reach this block as 1-bit levels. Each passes through a two-flop synchronizer before a loop acts on it. Searching only advances on cycles where the step enable is high.

Top module: `bias_cal_ctrl`

## Requirements
- R1: After reset, lo_code is the all-ones code (7 with 3-bit codes) and hi_code is 0. lo_lock, hi_lock, lo_fail, hi_fail, cal_done and bound_invalid are 0, bias_code is 0, and both loops are searching.
- R2: While the lower loop is searching, each clock with step_en high and no synchronized detector trip lowers lo_code by exactly one. A clock with step_en low leaves it unchanged.
- R3: While the upper loop is searching, each clock with step_en high and no synchronized detector trip raises hi_code by exactly one. A clock with step_en low leaves it unchanged.
- R4: A step taken while a loop's synchronized detector is high locks that loop at its current code. The code and the lock then stay frozen until recalibration.
- R5: Each raw detector input reaches its loop through a two-flop synchronizer. If steps are taken on every clock, the lower loop locks two codes below the first code at which its raw detector is high, and the upper loop locks two codes above it.
- R6: A step taken at the end of the range (lo_code 0, or hi_code all ones) with the synchronized detector low sets that loop's fail flag. The code stays at the range end, and the loop takes no further steps.
- R7: One clock after both loops are locked, cal_done rises. If lo_code is not above hi_code, bias_code becomes (lo_code + hi_code) >> 1, computed with a sum one bit wider than a code, so it rounds down.
- R8: If the locked lo_code is greater than the locked hi_code, bound_invalid rises together with cal_done and bias_code takes lo_code.
- R9: cal_done is high only while both loops are locked. While cal_done is low, including when a loop has failed, bias_code keeps its previous value.
- R10: A cal_start pulse clears both locks, both fail flags, cal_done and bound_invalid, and reloads lo_code and hi_code to their start codes on the next clock. It takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Recalibration request, one-cycle pulse |
| step_en | input | 1 | Search step enable for both loops |
| det_lo_raw | input | 1 | Worst-case read-zero detector level (lower-bound loop) |
| det_hi_raw | input | 1 | Worst-case read-one detector level (upper-bound loop) |
| bias_code | output | CODE_W | Published bias code |
| cal_done | output | 1 | Both loops locked and bias_code updated |
| bound_invalid | output | 1 | Locked lower bound exceeds upper bound |
| lo_code | output | CODE_W | Lower-bound loop code |
| hi_code | output | CODE_W | Upper-bound loop code |
| lo_lock | output | 1 | Lower-bound loop locked |
| hi_lock | output | 1 | Upper-bound loop locked |
| lo_fail | output | 1 | Lower-bound loop reached code 0 without a trip |
| hi_fail | output | 1 | Upper-bound loop reached the top code without a trip |

## Verification
A wrong step direction, or a loop that steps while step_en is low, shows on lo_code or hi_code at the very next clock. A loop that ignores its detector overshoots the expected lock code by the next step. A synchronizer with the wrong depth moves the lock point under continuous stepping by one code per missing or extra stage. This shows as soon as the loop freezes. A wrong midpoint, a wrong rounding or a missed crossed-bound case appears on bias_code and bound_invalid in the clock after the second lock. A bias code that does not hold while cal_done is low shows in the first cycle after a recalibration pulse.

// File: rtl/bias_cal_pkg.sv
package bias_cal_pkg;

    // Default width of one search code
    localparam int BIAS_CODE_W = 3;
    // Default synchronizer depth for the detector levels
    localparam int DET_SYNC_STAGES = 2;

    // Direction in which a search loop walks its code
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } search_dir_e;

    // Per-loop search state
    typedef enum logic [1:0] {
        LS_SEARCH = 2'd0,
        LS_LOCKED = 2'd1,
        LS_FAILED = 2'd2
    } loop_state_e;

    // Status a loop reports to the combiner
    typedef struct packed {
        logic locked;
        logic failed;
    } loop_status_t;

    // Decoded step decision for one loop in one cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_MOVE = 2'd1,
        ACT_LOCK = 2'd2,
        ACT_FAIL = 2'd3
    } loop_action_e;

    function automatic loop_action_e decide_action(
        input loop_state_e st,
        input logic        step,
        input logic        det,
        input logic        at_end
    );
        loop_action_e act;
        act = ACT_HOLD;
        if (st == LS_SEARCH && step) begin
            if (det)         act = ACT_LOCK;
            else if (at_end) act = ACT_FAIL;
            else             act = ACT_MOVE;
        end
        return act;
    endfunction

endpackage

// File: rtl/bias_det_sync.sv
module bias_det_sync #(
    parameter int STAGES = bias_cal_pkg::DET_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bias_search_loop.sv
module bias_search_loop
    import bias_cal_pkg::*;
#(
    parameter int          CODE_W = BIAS_CODE_W,
    parameter search_dir_e DIR    = DIR_DOWN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              step,
    input  logic              det,
    output logic [CODE_W-1:0] code,
    output loop_status_t      status
);
    localparam logic [CODE_W-1:0] CODE_MAX   = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN   = '0;
    localparam logic [CODE_W-1:0] CODE_START = (DIR == DIR_DOWN) ? CODE_MAX : CODE_MIN;
    localparam logic [CODE_W-1:0] CODE_END   = (DIR == DIR_DOWN) ? CODE_MIN : CODE_MAX;

    loop_state_e       state_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_moved;
    loop_action_e      action;

    generate
        if (DIR == DIR_DOWN) begin : g_down
            assign code_moved = code_q - 1'b1;
        end else begin : g_up
            assign code_moved = code_q + 1'b1;
        end
    endgenerate

    always_comb begin
        action = decide_action(state_q, step, det, code_q == CODE_END);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q <= LS_SEARCH;
            code_q  <= CODE_START;
        end else begin
            unique case (action)
                ACT_MOVE: code_q  <= code_moved;
                ACT_LOCK: state_q <= LS_LOCKED;
                ACT_FAIL: state_q <= LS_FAILED;
                default:  ;
            endcase
        end
    end

    assign code          = code_q;
    assign status.locked = (state_q == LS_LOCKED);
    assign status.failed = (state_q == LS_FAILED);
endmodule

// File: rtl/bias_mid_combine.sv
module bias_mid_combine
    import bias_cal_pkg::*;
#(
    parameter int CODE_W = BIAS_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  loop_status_t      lo_status,
    input  loop_status_t      hi_status,
    input  logic [CODE_W-1:0] lo_code,
    input  logic [CODE_W-1:0] hi_code,
    output logic [CODE_W-1:0] bias_code,
    output logic              done,
    output logic              invalid
);
    localparam int SUM_W = CODE_W + 1;

    logic [SUM_W-1:0]  sum;
    logic [CODE_W-1:0] mid;
    logic              crossed;
    logic              both_locked;
    logic [CODE_W-1:0] bias_q;
    logic              done_q;
    logic              invalid_q;

    assign sum         = {1'b0, lo_code} + {1'b0, hi_code};
    assign mid         = CODE_W'(sum >> 1);
    assign crossed     = lo_code > hi_code;
    assign both_locked = lo_status.locked && hi_status.locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            bias_q    <= '0;
            done_q    <= 1'b0;
            invalid_q <= 1'b0;
        end else if (restart) begin
            done_q    <= 1'b0;
            invalid_q <= 1'b0;
        end else if (both_locked && !done_q) begin
            done_q    <= 1'b1;
            invalid_q <= crossed;
            bias_q    <= crossed ? lo_code : mid;
        end
    end

    assign bias_code = bias_q;
    assign done      = done_q;
    assign invalid   = invalid_q;
endmodule

// File: rtl/bias_cal_ctrl.sv
module bias_cal_ctrl
    import bias_cal_pkg::*;
#(
    parameter int CODE_W      = BIAS_CODE_W,
    parameter int SYNC_STAGES = DET_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_start,
    input  logic              step_en,
    input  logic              det_lo_raw,
    input  logic              det_hi_raw,
    output logic [CODE_W-1:0] bias_code,
    output logic              cal_done,
    output logic              bound_invalid,
    output logic [CODE_W-1:0] lo_code,
    output logic [CODE_W-1:0] hi_code,
    output logic              lo_lock,
    output logic              hi_lock,
    output logic              lo_fail,
    output logic              hi_fail
);
    logic         lo_det_s;
    logic         hi_det_s;
    loop_status_t lo_status;
    loop_status_t hi_status;

    bias_det_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
        .clk (clk), .rst (rst), .din (det_lo_raw), .dout (lo_det_s)
    );

    bias_det_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
        .clk (clk), .rst (rst), .din (det_hi_raw), .dout (hi_det_s)
    );

    bias_search_loop #(.CODE_W(CODE_W), .DIR(DIR_DOWN)) u_loop_lo (
        .clk     (clk),
        .rst     (rst),
        .restart (cal_start),
        .step    (step_en),
        .det     (lo_det_s),
        .code    (lo_code),
        .status  (lo_status)
    );

    bias_search_loop #(.CODE_W(CODE_W), .DIR(DIR_UP)) u_loop_hi (
        .clk     (clk),
        .rst     (rst),
        .restart (cal_start),
        .step    (step_en),
        .det     (hi_det_s),
        .code    (hi_code),
        .status  (hi_status)
    );

    bias_mid_combine #(.CODE_W(CODE_W)) u_combine (
        .clk       (clk),
        .rst       (rst),
        .restart   (cal_start),
        .lo_status (lo_status),
        .hi_status (hi_status),
        .lo_code   (lo_code),
        .hi_code   (hi_code),
        .bias_code (bias_code),
        .done      (cal_done),
        .invalid   (bound_invalid)
    );

    assign lo_lock = lo_status.locked;
    assign hi_lock = hi_status.locked;
    assign lo_fail = lo_status.failed;
    assign hi_fail = hi_status.failed;
endmodule

// File: rtl/bias_cal_checker.sv
module bias_cal_checker #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cal_start,
    input logic              step_en,
    input logic              lo_det_s,
    input logic              hi_det_s,
    input logic [CODE_W-1:0] bias_code,
    input logic              cal_done,
    input logic              bound_invalid,
    input logic [CODE_W-1:0] lo_code,
    input logic [CODE_W-1:0] hi_code,
    input logic              lo_lock,
    input logic              hi_lock,
    input logic              lo_fail,
    input logic              hi_fail
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    // R2: a searching lower loop moves down by one on a clean step
    a_r2_lo_step: assert property (@(posedge clk) disable iff (rst)
        (!lo_lock && !lo_fail && step_en && !cal_start && !lo_det_s && lo_code != '0)
        |=> lo_code == $past(lo_code) - CODE_W'(1));

    // R3: a searching upper loop moves up by one on a clean step
    a_r3_hi_step: assert property (@(posedge clk) disable iff (rst)
        (!hi_lock && !hi_fail && step_en && !cal_start && !hi_det_s && hi_code != TOP)
        |=> hi_code == $past(hi_code) + CODE_W'(1));

    // R4: a lock only comes from a step that saw the synchronized detector
    a_r4_lo_lock_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_lock) |-> $past(step_en) && $past(lo_det_s) && !$past(cal_start));

    // R4: a locked loop keeps its code until recalibration
    a_r4_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (lo_lock && !cal_start) |=> (lo_lock && $stable(lo_code)));

    // R6: a failed loop sits at its range end and is not locked
    a_r6_fail_end: assert property (@(posedge clk) disable iff (rst)
        (lo_fail |-> (lo_code == '0 && !lo_lock)) and (hi_fail |-> (hi_code == TOP && !hi_lock)));

    // R7: done follows both locks by one clock
    a_r7_done_timing: assert property (@(posedge clk) disable iff (rst)
        (lo_lock && hi_lock && !cal_done && !cal_start) |=> cal_done);

    // R7: published code is the floor midpoint for ordered bounds
    a_r7_midpoint: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !bound_invalid) |-> (({1'b0, bias_code} << 1) == ({1'b0, lo_code} + {1'b0, hi_code})
                                           || (({1'b0, bias_code} << 1) + 1) == ({1'b0, lo_code} + {1'b0, hi_code})));

    // R8: crossed bounds publish the lower bound
    a_r8_invalid: assert property (@(posedge clk) disable iff (rst)
        (cal_done && bound_invalid) |-> (bias_code == lo_code && lo_code > hi_code));

    // R9: done implies both locks, and the bias code holds while not done
    a_r9_done_locks: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> (lo_lock && hi_lock));
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !cal_done |-> $stable(bias_code));

    // R10: recalibration reloads start codes and clears flags
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        cal_start |=> (lo_code == TOP && hi_code == '0 && !lo_lock && !hi_lock
                       && !lo_fail && !hi_fail && !cal_done && !bound_invalid));
endmodule

bind bias_cal_ctrl bias_cal_checker #(.CODE_W(CODE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cal_start     (cal_start),
    .step_en       (step_en),
    .lo_det_s      (lo_det_s),
    .hi_det_s      (hi_det_s),
    .bias_code     (bias_code),
    .cal_done      (cal_done),
    .bound_invalid (bound_invalid),
    .lo_code       (lo_code),
    .hi_code       (hi_code),
    .lo_lock       (lo_lock),
    .hi_lock       (hi_lock),
    .lo_fail       (lo_fail),
    .hi_fail       (hi_fail)
);

// File: tb/sim_bias_cal_ctrl.sv
`timescale 1ns/1ps
module sim_bias_cal_ctrl;
    localparam int W = 3;
    localparam int NV = 8;
    // trip_lo, trip_hi, expected bias, expected invalid
    localparam int VECS [NV][4] = '{
        '{2, 5, 3, 0}, '{0, 7, 3, 0}, '{7, 0, 7, 1}, '{3, 3, 3, 0},
        '{4, 5, 4, 0}, '{5, 2, 5, 1}, '{1, 6, 3, 0}, '{6, 7, 6, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cal_start = 1'b0;
    logic step_en = 1'b0;
    logic det_lo_raw, det_hi_raw;
    logic [W-1:0] bias_code, lo_code, hi_code;
    logic cal_done, bound_invalid, lo_lock, hi_lock, lo_fail, hi_fail;

    int trip_lo = -1;
    int trip_hi = 8;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int prev_bias = 0;

    always #2 clk = ~clk;

    // detector model: lower detector high once lo_code is at or below its trip point
    assign det_lo_raw = (int'(lo_code) <= trip_lo);
    assign det_hi_raw = (int'(hi_code) >= trip_hi);

    bias_cal_ctrl #(.CODE_W(W)) u0 (
        .clk (clk), .rst (rst), .cal_start (cal_start), .step_en (step_en),
        .det_lo_raw (det_lo_raw), .det_hi_raw (det_hi_raw),
        .bias_code (bias_code), .cal_done (cal_done), .bound_invalid (bound_invalid),
        .lo_code (lo_code), .hi_code (hi_code), .lo_lock (lo_lock), .hi_lock (hi_lock),
        .lo_fail (lo_fail), .hi_fail (hi_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart_cal();
        trip_lo = -1;
        trip_hi = 8;
        repeat (4) @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    task automatic run_steps(input int period, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            step_en = (period != 0) && ((i % period) == period - 1);
            @(negedge clk);
        end
        step_en = 1'b0;
    endtask

    task automatic check_result(input string req, input int elo, input int ehi,
                                input int ebias, input int einv, input int edone);
        chk({req, " lo_code"}, int'(lo_code), elo);
        chk({req, " hi_code"}, int'(hi_code), ehi);
        chk({req, " cal_done"}, int'(cal_done), edone);
        chk({req, " bias_code"}, int'(bias_code), ebias);
        if (edone != 0) chk({req, " bound_invalid"}, int'(bound_invalid), einv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 lo_code", int'(lo_code), 7);
        chk("R1 hi_code", int'(hi_code), 0);
        chk("R1 flags", int'({lo_lock, hi_lock, lo_fail, hi_fail, cal_done, bound_invalid}), 0);
        chk("R1 bias_code", int'(bias_code), 0);

        // R2 R3: no step_en, no movement
        run_steps(0, 12);
        chk("R2 hold lo", int'(lo_code), 7);
        chk("R3 hold hi", int'(hi_code), 0);

        // R2 R3: one step moves each loop by one
        run_steps(4, 4);
        chk("R2 one step lo", int'(lo_code), 6);
        chk("R3 one step hi", int'(hi_code), 1);

        // R10: restart reloads codes
        restart_cal();
        chk("R10 lo reload", int'(lo_code), 7);
        chk("R10 hi reload", int'(hi_code), 0);

        // vector table walk: R4 R7 R8, slow stepping so the lock lands on the trip code
        for (int v = 0; v < NV; v++) begin
            restart_cal();
            chk("R9 done low after restart", int'(cal_done), 0);
            chk("R9 bias holds after restart", int'(bias_code), prev_bias);
            trip_lo = VECS[v][0];
            trip_hi = VECS[v][1];
            run_steps(4, 48);
            check_result((VECS[v][3] != 0) ? "R8 vec" : "R7 vec",
                         VECS[v][0], VECS[v][1], VECS[v][2], VECS[v][3], 1);
            chk("R4 locks", int'({lo_lock, hi_lock}), 3);
            prev_bias = VECS[v][2];
        end

        // R4: locked code ignores further steps
        run_steps(1, 10);
        chk("R4 frozen lo", int'(lo_code), VECS[NV-1][0]);
        chk("R4 frozen hi", int'(hi_code), VECS[NV-1][1]);

        // R5: continuous stepping overshoots by the synchronizer depth
        restart_cal();
        trip_lo = 5;
        trip_hi = 2;
        run_steps(1, 20);
        check_result("R5 sync", 3, 4, 3, 0, 1);
        prev_bias = 3;

        // R6 R9: lower loop never trips
        restart_cal();
        trip_lo = -1;
        trip_hi = 3;
        run_steps(4, 60);
        chk("R6 lo_fail", int'(lo_fail), 1);
        check_result("R9 lo failed", 0, 3, prev_bias, 0, 0);

        // R6 R9: upper loop never trips
        restart_cal();
        trip_lo = 4;
        trip_hi = 8;
        run_steps(4, 60);
        chk("R6 hi_fail", int'(hi_fail), 1);
        check_result("R9 hi failed", 4, 7, prev_bias, 0, 0);

        // R10: restart in same cycle as a step wins
        trip_lo = -1;
        trip_hi = 8;
        cal_start = 1'b1;
        step_en = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        step_en = 1'b0;
        chk("R10 priority lo", int'(lo_code), 7);
        chk("R10 flags cleared", int'({lo_fail, hi_fail, cal_done}), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule